// File: doc/BRIEF.md
# Dual-Owner GPIO Controller

A 24-pin general-purpose I/O bank shared by two processors. Each processor reaches the bank through its own 32-bit register window, and each window holds its own output, direction, interrupt-polarity, interrupt-flag and interrupt-enable registers. A per-pin owner register decides which window's output value and direction reach each pad. A bank-wide output-enable mask can keep any pad undriven, whichever window owns it.

Pad inputs pass through a two-stage synchronizer. The synchronized value feeds the input readback, the per-window interrupt detection and a one-shot snapshot register. Each window raises its own interrupt line. That line is the OR of the window's enabled, sticky flags.

Top module: `gpio_dual_ctrl`

## Requirements
- R1: After reset, every output, direction, polarity, flag and enable register in both windows and the owner register read 0. The output-enable mask reads 0x00FFFFFF. Both interrupt lines and every pad_oe_o bit are 0.
- R2: Register word offsets are the same in both windows. They are: output 0x00, direction 0x04, input 0x08, polarity 0x0C, flag 0x10, enable 0x14, snapshot 0x18, owner 0x1C and output-enable mask 0x20. The input register returns the pad value two clock edges after the pad changes.
- R3: For a pin whose owner bit is 0, window A's output and direction bits drive pad_out_o and pad_oe_o. For a pin whose owner bit is 1, window B's bits drive them. A direction bit of 1 means output.
- R4: A window that does not own a pin still stores writes to that pin's output and direction bits and reads them back, but those bits do not change the pad.
- R5: pad_oe_o is 0 on every pin whose output-enable mask bit is 0. Either window may write the mask. Mask bits at and above bit 24 cannot be set and read as 0.
- R6: A window's flag bit is set on the first cycle in which the synchronized input matches that window's polarity bit (1 means active-high, 0 means active-low). The flag stays set after the input leaves that level.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. When a new match and a clear land on the same cycle, the flag ends up set.
- R8: Each window's interrupt output is high exactly when some flag bit of that window has its enable bit set.
- R9: The owner register is written only from window A. A write from window B leaves it unchanged. Both windows read it.
- R10: The snapshot register takes the synchronized pad value once, on the third clock edge after reset is released, and holds it until the next reset.
- R11: A read at an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_sel_i | input | 1 | Window A access strobe |
| a_we_i | input | 1 | Window A write (1) or read (0) |
| a_addr_i | input | 6 | Window A byte offset |
| a_wdata_i | input | 32 | Window A write data |
| a_rdata_o | output | 32 | Window A read data (combinational) |
| b_sel_i | input | 1 | Window B access strobe |
| b_we_i | input | 1 | Window B write (1) or read (0) |
| b_addr_i | input | 6 | Window B byte offset |
| b_wdata_i | input | 32 | Window B write data |
| b_rdata_o | output | 32 | Window B read data (combinational) |
| pad_in_i | input | 24 | Asynchronous pad inputs |
| pad_out_o | output | 24 | Pad output values |
| pad_oe_o | output | 24 | Pad output-driver enables |
| a_irq_o | output | 1 | Window A interrupt |
| b_irq_o | output | 1 | Window B interrupt |

## Verification
The hardest case to reach is the collision in which a write-1-to-clear and a fresh polarity match land on the same clock edge. The bench first re-arms the pin by taking it out of the matching level. It then changes the pad on a falling edge, lets exactly two rising edges pass so that the match reaches the end of the synchronizer, and issues the clearing write so that it is captured on the third edge. The snapshot register is the other hard case: the pad is held at a fixed pattern through reset and for several cycles after it, and then changed, to show that the register captured the pattern once and then held it.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int unsigned IDX_OUT  = 0;
  localparam int unsigned IDX_DIR  = 1;
  localparam int unsigned IDX_IN   = 2;
  localparam int unsigned IDX_LVL  = 3;
  localparam int unsigned IDX_FLAG = 4;
  localparam int unsigned IDX_IEN  = 5;
  localparam int unsigned IDX_MIR  = 6;
  localparam int unsigned IDX_OWN  = 7;
  localparam int unsigned IDX_OEN  = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_win.sv
module gpio_win
  import gpio_dual_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] sin_i,
  input  logic [NUM_PINS-1:0] mirror_i,
  input  logic [NUM_PINS-1:0] owner_i,
  input  logic [NUM_PINS-1:0] oen_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic                irq_o,
  output logic                wr_own_o,
  output logic                wr_oen_o
);
  localparam int unsigned WW = ADDR_W - 2;

  logic [WW-1:0]       word;
  logic                wr;
  logic [NUM_PINS-1:0] wd;
  logic                wr_out, wr_dir, wr_lvl, wr_flag, wr_ien;
  logic [NUM_PINS-1:0] out_q, dir_q, lvl_q, flag_q, ien_q, match_q;
  logic [NUM_PINS-1:0] match, hit, clr;
  logic                unused_bits;

  assign word        = addr_i[ADDR_W-1:2];
  assign wr          = sel_i & we_i;
  assign wd          = wdata_i[NUM_PINS-1:0];
  assign unused_bits = ^{wdata_i, addr_i[1:0]};

  assign wr_out   = wr && (word == WW'(IDX_OUT));
  assign wr_dir   = wr && (word == WW'(IDX_DIR));
  assign wr_lvl   = wr && (word == WW'(IDX_LVL));
  assign wr_flag  = wr && (word == WW'(IDX_FLAG));
  assign wr_ien   = wr && (word == WW'(IDX_IEN));
  assign wr_own_o = wr && (word == WW'(IDX_OWN));
  assign wr_oen_o = wr && (word == WW'(IDX_OEN));

  // polarity match, flag on its rising edge; set beats clear
  assign match = ~(sin_i ^ lvl_q);
  assign hit   = match & ~match_q;
  assign clr   = wr_flag ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      lvl_q   <= '0;
      flag_q  <= '0;
      ien_q   <= '0;
      match_q <= '1;
    end else begin
      if (wr_out) out_q <= wd;
      if (wr_dir) dir_q <= wd;
      if (wr_lvl) lvl_q <= wd;
      if (wr_ien) ien_q <= wd;
      flag_q  <= (flag_q & ~clr) | hit;
      match_q <= match;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      case (word)
        WW'(IDX_OUT):  rdata_o[NUM_PINS-1:0] = out_q;
        WW'(IDX_DIR):  rdata_o[NUM_PINS-1:0] = dir_q;
        WW'(IDX_IN):   rdata_o[NUM_PINS-1:0] = sin_i;
        WW'(IDX_LVL):  rdata_o[NUM_PINS-1:0] = lvl_q;
        WW'(IDX_FLAG): rdata_o[NUM_PINS-1:0] = flag_q;
        WW'(IDX_IEN):  rdata_o[NUM_PINS-1:0] = ien_q;
        WW'(IDX_MIR):  rdata_o[NUM_PINS-1:0] = mirror_i;
        WW'(IDX_OWN):  rdata_o[NUM_PINS-1:0] = owner_i;
        WW'(IDX_OEN):  rdata_o[NUM_PINS-1:0] = oen_i;
        default:       rdata_o = '0;
      endcase
    end
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
  assign irq_o = |(flag_q & ien_q);

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && word > WW'(IDX_OEN)) |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl #(
  parameter int unsigned NUM_PINS    = 24,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                a_sel_i,
  input  logic                a_we_i,
  input  logic [ADDR_W-1:0]   a_addr_i,
  input  logic [DATA_W-1:0]   a_wdata_i,
  output logic [DATA_W-1:0]   a_rdata_o,
  input  logic                b_sel_i,
  input  logic                b_we_i,
  input  logic [ADDR_W-1:0]   b_addr_i,
  input  logic [DATA_W-1:0]   b_wdata_i,
  output logic [DATA_W-1:0]   b_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                a_irq_o,
  output logic                b_irq_o
);
  localparam int unsigned CNT_W    = $clog2(SYNC_STAGES + 2);
  localparam int unsigned CAP_STEP = SYNC_STAGES;

  logic [NUM_PINS-1:0] sin, mir_q, own_q, oen_q;
  logic [NUM_PINS-1:0] out_a, dir_a, out_b, dir_b;
  logic                a_wr_own, a_wr_oen, b_wr_own, b_wr_oen;
  logic [CNT_W-1:0]    cap_cnt;
  logic                cap_done;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(sin));

  gpio_win #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_win_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(a_sel_i), .we_i(a_we_i),
    .addr_i(a_addr_i), .wdata_i(a_wdata_i), .rdata_o(a_rdata_o),
    .sin_i(sin), .mirror_i(mir_q), .owner_i(own_q), .oen_i(oen_q),
    .out_o(out_a), .dir_o(dir_a), .irq_o(a_irq_o),
    .wr_own_o(a_wr_own), .wr_oen_o(a_wr_oen));

  gpio_win #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_win_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(b_sel_i), .we_i(b_we_i),
    .addr_i(b_addr_i), .wdata_i(b_wdata_i), .rdata_o(b_rdata_o),
    .sin_i(sin), .mirror_i(mir_q), .owner_i(own_q), .oen_i(oen_q),
    .out_o(out_b), .dir_o(dir_b), .irq_o(b_irq_o),
    .wr_own_o(b_wr_own), .wr_oen_o(b_wr_oen));

  // owner writable from window A only; mask from either, A first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
      oen_q <= '1;
    end else begin
      if (a_wr_own) own_q <= a_wdata_i[NUM_PINS-1:0];
      if (a_wr_oen)      oen_q <= a_wdata_i[NUM_PINS-1:0];
      else if (b_wr_oen) oen_q <= b_wdata_i[NUM_PINS-1:0];
    end
  end

  // snapshot once the synchronizer holds its first real sample
  assign cap_done = (cap_cnt == CNT_W'(CAP_STEP + 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_cnt <= '0;
      mir_q   <= '0;
    end else if (!cap_done) begin
      cap_cnt <= cap_cnt + 1'b1;
      if (cap_cnt == CNT_W'(CAP_STEP)) mir_q <= sin;
    end
  end

  assign pad_out_o = (own_q & out_b) | (~own_q & out_a);
  assign pad_oe_o  = ((own_q & dir_b) | (~own_q & dir_a)) & oen_q;

  p_oe_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~oen_q) == '0);

  p_owner_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_wr_own && !a_wr_own) |=> $stable(own_q));

  p_mirror_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_done |=> $stable(mir_q));
endmodule

// File: tb/gpio_dual_ctrl_tb.sv
module gpio_dual_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [23:0] pad_in = 24'hA5C396;
  logic [23:0] pad_out, pad_oe;
  logic        a_irq, b_irq;
  int          n_chk = 0, n_bad = 0;

  localparam logic [5:0] O_OUT = 6'h00, O_DIR = 6'h04, O_IN = 6'h08, O_LVL = 6'h0C,
    O_FLAG = 6'h10, O_IEN = 6'h14, O_MIR = 6'h18, O_OWN = 6'h1C, O_OEN = 6'h20;

  always #10 clk = ~clk;

  gpio_dual_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_sel_i(a_sel), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_rdata_o(a_rdata),
    .b_sel_i(b_sel), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wdata), .b_rdata_o(b_rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .a_irq_o(a_irq), .b_irq_o(b_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input bit win_b, input logic [5:0] a, input logic [31:0] d);
    if (win_b) begin b_sel = 1; b_we = 1; b_addr = a; b_wdata = d; end
    else       begin a_sel = 1; a_we = 1; a_addr = a; a_wdata = d; end
    @(negedge clk);
    a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
  endtask

  task automatic rd(input bit win_b, input logic [5:0] a, output logic [31:0] d);
    if (win_b) begin b_sel = 1; b_we = 0; b_addr = a; end
    else       begin a_sel = 1; a_we = 0; a_addr = a; end
    #1;
    d = win_b ? b_rdata : a_rdata;
    a_sel = 0; b_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, O_OUT, v);  chk("R1 A out", v, 0);
    rd(1, O_DIR, v);  chk("R1 B dir", v, 0);
    rd(0, O_OWN, v);  chk("R1 owner", v, 0);
    rd(1, O_FLAG, v); chk("R1 B flag", v, 0);
    rd(0, O_OEN, v);  chk("R1 mask", v, 32'h00FFFFFF);
    chk("R1 pad_oe", {8'h0, pad_oe}, 0);
    chk("R1 irqs", {30'h0, a_irq, b_irq}, 0);
    rd(0, O_MIR, v);  chk("R10 snapshot", v, 32'h00A5C396);
    pad_in = 24'h123456;
    idle(4);
    rd(1, O_MIR, v);  chk("R10 snapshot held", v, 32'h00A5C396);
    rd(0, O_IN, v);   chk("R2 A input", v, 32'h00123456);
    rd(1, O_IN, v);   chk("R2 B input", v, 32'h00123456);
    rd(0, 6'h24, v);  chk("R11 unmapped", v, 0);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr(0, O_OUT, 32'h0000F0F0); wr(0, O_DIR, 32'h0000FFFF);
    wr(1, O_OUT, 32'h00FF0000); wr(1, O_DIR, 32'h00FF00FF);
    chk("R3 A owns oe", {8'h0, pad_oe}, 32'h0000FFFF);
    chk("R3 A owns out", {8'h0, pad_out}, 32'h0000F0F0);
    wr(0, O_OWN, 32'h00FF00FF);
    chk("R3 split oe", {8'h0, pad_oe}, 32'h00FFFFFF);
    chk("R3 split out", {8'h0, pad_out}, 32'h00FFF000);
    wr(1, O_OUT, 32'h00000F00);
    chk("R4 non-owner out no effect", {8'h0, pad_out}, 32'h0000F000);
    rd(1, O_OUT, v); chk("R4 non-owner stored", v, 32'h00000F00);
  endtask

  task automatic t_owner_ro;
    logic [31:0] v;
    wr(1, O_OWN, 32'h0);
    rd(0, O_OWN, v); chk("R9 owner kept (A)", v, 32'h00FF00FF);
    rd(1, O_OWN, v); chk("R9 owner kept (B)", v, 32'h00FF00FF);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(0, O_OEN, 32'hFFFF00FF);
    rd(0, O_OEN, v); chk("R5 top bits", v, 32'h00FF00FF);
    chk("R5 masked oe", {8'h0, pad_oe}, 32'h00FF00FF);
    wr(1, O_OEN, 32'hFFFFFFFF);
    rd(1, O_OEN, v); chk("R5 B writes mask", v, 32'h00FFFFFF);
    chk("R5 oe restored", {8'h0, pad_oe}, 32'h00FFFFFF);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    pad_in = 24'h0; idle(4);
    wr(0, O_FLAG, 32'hFFFFFFFF); wr(1, O_FLAG, 32'hFFFFFFFF);
    rd(0, O_FLAG, v); chk("R7 all cleared", v, 0);
    wr(0, O_LVL, 32'h1);
    pad_in = 24'h1; idle(4);
    rd(0, O_FLAG, v); chk("R6 active-high flag", v, 32'h1);
    rd(1, O_FLAG, v); chk("R6 B no flag on rise", v, 0);
    chk("R8 irq off when disabled", {31'h0, a_irq}, 0);
    wr(0, O_IEN, 32'h1);
    chk("R8 irq on", {31'h0, a_irq}, 1);
    pad_in = 24'h0; idle(4);
    rd(0, O_FLAG, v); chk("R6 sticky", v, 32'h1);
    rd(1, O_FLAG, v); chk("R6 active-low flag", v, 32'h1);
    wr(0, O_FLAG, 32'h0);
    rd(0, O_FLAG, v); chk("R7 write 0 keeps", v, 32'h1);
    wr(0, O_FLAG, 32'h1);
    rd(0, O_FLAG, v); chk("R7 write 1 clears", v, 0);
    chk("R8 irq drops", {31'h0, a_irq}, 0);
    chk("R8 B irq disabled", {31'h0, b_irq}, 0);
    wr(1, O_IEN, 32'h1);
    chk("R8 B irq on", {31'h0, b_irq}, 1);
    // match lands on the third edge after pad change, same edge as clear
    pad_in = 24'h1;
    @(negedge clk); @(negedge clk);
    wr(0, O_FLAG, 32'h1);
    rd(0, O_FLAG, v); chk("R7 set wins over clear", v, 32'h1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(6);
    t_reset;
    t_route;
    t_owner_ro;
    t_mask;
    t_irq;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule